// File: doc/BRIEF.md
# Read Credit Replenishment Controller

This block sits on the completer side of a request path and hands read-request credits to an upstream request source. The source may only issue a non-posted read while it holds a credit, and each read consumes one. The controller keeps the source supplied so that a chosen number of reads can be in flight without the source stalling on a credit round trip.

Leaving reset, the controller grants a start-up batch of credits equal to the parameter `TARGET`. It sends this batch two credits per cycle, with a single credit in the last cycle when `TARGET` is odd. After that, every read pulse it observes adds one to an internal owed count. Owed credits go back to the source at up to two per cycle, unless the downstream read engine asks for them to be withheld. Raising `TARGET` from 2 to 4 or 8 lets more reads overlap, which hides the latency between a credit grant and the next read.

Top module: `rd_credit_refill`

## Requirements
- R1: While `rstN` is low, `creditGrant` reads 0.
- R2: Starting in the first cycle after reset is released, the block grants two credits per cycle on consecutive cycles until `TARGET` credits have been granted. If `TARGET` is odd, the last of these cycles grants one credit. The batch therefore occupies ceil(`TARGET`/2) cycles.
- R3: `creditGrant` carries a plain count of credits: 0 is none, 1 is one credit and 2 is two credits. The value 3 never appears.
- R4: Each read pulse sampled on a clock edge is paid back with exactly one credit. That credit appears no earlier than the cycle after the next edge. When nothing is owed, the grant is 0.
- R5: With returns allowed and two or more credits owed, the next cycle grants two credits. With one credit owed, it grants one.
- R6: Reads that arrive while the start-up batch is still being sent are remembered. Their credits are returned once the batch is complete.
- R7: While `holdReturns` is high on an edge after the start-up batch, the grant that follows is 0 and owed credits keep accumulating. After release they are paid out at the R5 rate.
- R8: At no time does the total granted minus the reads received exceed `TARGET`. Once all owed credits are returned, the source holds exactly `TARGET` credits.
- R9: `TARGET` may be any value from 1 to 32, and the values 2, 4, 5 and 8 all behave as above.
- R10: `holdReturns` does not delay or reduce the start-up batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| readSeen | input | 1 | One-cycle pulse for each non-posted read received |
| holdReturns | input | 1 | Downstream request to withhold credit returns |
| creditGrant | output | 2 | Credits granted this cycle (0, 1 or 2) |

## Verification
Two things can land on the same edge: a new read pulse arriving, and the payout of credits owed for earlier reads. The start-up batch or a release of `holdReturns` can also coincide with that payout. The bench drives read pulses in every 8-cycle pattern, both with returns open and with `holdReturns` patterns interleaved, starting from a batch with reads folded in. This puts pulses on exactly the edges where owed credits leave. Each grant is compared against an arithmetic count of owed credits, and the source balance must never exceed `TARGET` and must settle back to it.

// File: rtl/rd_credit_refill_pkg.sv
package rd_credit_refill_pkg;
  localparam int GRANT_W = 2;
  localparam int MAX_TARGET = 32;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic initActive;  // start-up batch still being sent
    logic initPair;    // at least two start-up credits remain
    logic returnEn;    // owed credits may be paid out
  } ctrlStrobes_t;
endpackage

// File: rtl/rd_credit_refill_ctrl.sv
module rd_credit_refill_ctrl
  import rd_credit_refill_pkg::*;
#(
  parameter int TARGET = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         holdReturns,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(TARGET + 1);
  localparam logic [CNT_W-1:0] TARGET_C = CNT_W'(TARGET);

  logic [CNT_W-1:0] initLeft;

  always_comb begin
    strobes.initActive = (initLeft != '0);
    strobes.initPair   = (initLeft > CNT_W'(1));
    strobes.returnEn   = (initLeft == '0) && !holdReturns;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initLeft <= TARGET_C;
    end else if (strobes.initActive) begin
      initLeft <= strobes.initPair ? (initLeft - CNT_W'(2)) : '0;
    end
  end
endmodule

// File: rtl/rd_credit_refill_path.sv
module rd_credit_refill_path
  import rd_credit_refill_pkg::*;
#(
  parameter int TARGET = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               readSeen,
  input  ctrlStrobes_t       strobes,
  output logic [GRANT_W-1:0] creditGrant
);
  localparam int CNT_W = $clog2(TARGET + 1);

  logic [CNT_W-1:0]   owed;
  logic [CNT_W-1:0]   owedNext;
  logic [GRANT_W-1:0] retCount;
  logic [GRANT_W-1:0] issue;

  always_comb begin
    if (!strobes.returnEn) begin
      retCount = 2'd0;
    end else if (owed > CNT_W'(1)) begin
      retCount = 2'd2;
    end else begin
      retCount = {1'b0, owed[0]};
    end
  end

  always_comb begin
    if (strobes.initActive) begin
      issue = strobes.initPair ? 2'd2 : 2'd1;
    end else begin
      issue = retCount;
    end
  end

  assign owedNext = owed - CNT_W'(retCount) + CNT_W'(readSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owed        <= '0;
      creditGrant <= '0;
    end else begin
      owed        <= owedNext;
      creditGrant <= issue;
    end
  end
endmodule

// File: rtl/rd_credit_refill.sv
module rd_credit_refill
  import rd_credit_refill_pkg::*;
#(
  parameter int TARGET = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       readSeen,
  input  logic       holdReturns,
  output logic [1:0] creditGrant
);
  generate
    if (TARGET < 1 || TARGET > MAX_TARGET) begin : g_badTarget
      $error("rd_credit_refill: TARGET must lie in 1..32");
    end
  endgenerate

  ctrlStrobes_t strobes;

  rd_credit_refill_ctrl #(.TARGET(TARGET)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .holdReturns(holdReturns),
    .strobes    (strobes)
  );

  rd_credit_refill_path #(.TARGET(TARGET)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .readSeen   (readSeen),
    .strobes    (strobes),
    .creditGrant(creditGrant)
  );
endmodule

// File: rtl/rd_credit_refill_chk.sv
module rd_credit_refill_chk #(
  parameter int TARGET = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       readSeen,
  input logic       holdReturns,
  input logic [1:0] creditGrant
);
  logic [31:0] sumGrant;
  logic [31:0] sumRead;
  logic [31:0] seenNow;
  logic [31:0] pending;
  logic        initDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumGrant <= '0;
      sumRead  <= '0;
    end else begin
      sumGrant <= sumGrant + 32'(creditGrant);
      sumRead  <= sumRead + 32'(readSeen);
    end
  end

  assign seenNow  = sumGrant + 32'(creditGrant);
  assign initDone = seenNow >= 32'(TARGET);
  assign pending  = sumRead + 32'(TARGET) - seenNow;

  p_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    creditGrant != 2'b11);

  p_batch_r2: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |=> creditGrant != 2'd0);

  p_ceiling_r8: assert property (@(posedge clk) disable iff (!rstN)
    seenNow <= sumRead + 32'(TARGET));

  p_no_early_r4: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && pending == 32'd0) |=> creditGrant == 2'd0);

  p_rate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && !holdReturns && pending >= 32'd2) |=> creditGrant == 2'd2);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && holdReturns) |=> creditGrant == 2'd0);
endmodule

bind rd_credit_refill rd_credit_refill_chk #(.TARGET(TARGET)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .readSeen   (readSeen),
  .holdReturns(holdReturns),
  .creditGrant(creditGrant)
);

// File: tb/sim_rd_credit_refill.sv
module sim_rd_credit_refill;
  localparam int NI = 4;
  localparam int TG [NI] = '{2, 4, 8, 5};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readSeen = 1'b0;
  logic holdReturns = 1'b0;
  logic [1:0] g [NI];

  rd_credit_refill u0 (.clk(clk), .rstN(rstN), .readSeen(readSeen),
    .holdReturns(holdReturns), .creditGrant(g[0]));
  rd_credit_refill #(.TARGET(4)) u1 (.clk(clk), .rstN(rstN), .readSeen(readSeen),
    .holdReturns(holdReturns), .creditGrant(g[1]));
  rd_credit_refill #(.TARGET(8)) u2 (.clk(clk), .rstN(rstN), .readSeen(readSeen),
    .holdReturns(holdReturns), .creditGrant(g[2]));
  rd_credit_refill #(.TARGET(5)) u3 (.clk(clk), .rstN(rstN), .readSeen(readSeen),
    .holdReturns(holdReturns), .creditGrant(g[3]));

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R1";
  int mInit [NI];
  int mOwed [NI];
  int mGrant [NI];
  int bal [NI];
  int winSum [NI];
  int winNz [NI];

  // Arithmetic expectation: start-up credits left and credits owed per target
  always @(posedge clk) begin
    for (int k = 0; k < NI; k++) begin
      int iss;
      if (!rstN) begin
        mInit[k] = TG[k];
        mOwed[k] = 0;
        mGrant[k] = 0;
      end else begin
        iss = 0;
        if (mInit[k] > 0) begin
          iss = (mInit[k] >= 2) ? 2 : 1;
          mInit[k] = mInit[k] - iss;
        end else if (!holdReturns) begin
          iss = (mOwed[k] >= 2) ? 2 : mOwed[k];
          mOwed[k] = mOwed[k] - iss;
        end
        mOwed[k] = mOwed[k] + (readSeen ? 1 : 0);
        mGrant[k] = iss;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clearWin();
    for (int k = 0; k < NI; k++) begin
      winSum[k] = 0;
      winNz[k] = 0;
    end
  endtask

  task automatic step(input bit wantRead, input bit hold);
    bit canRead;
    @(negedge clk);
    canRead = 1'b1;
    for (int k = 0; k < NI; k++) begin
      chk(int'(g[k]) == mGrant[k], curReq, int'(g[k]), mGrant[k]);
      chk(g[k] != 2'b11, "R3", int'(g[k]), 2);
      if (rstN) bal[k] = bal[k] + int'(g[k]);
      chk(bal[k] <= TG[k], "R8", bal[k], TG[k]);
      winSum[k] = winSum[k] + int'(g[k]);
      if (g[k] != 2'd0) winNz[k] = winNz[k] + 1;
      if (bal[k] < 1) canRead = 1'b0;
    end
    readSeen = wantRead && canRead && rstN;
    if (readSeen) begin
      for (int k = 0; k < NI; k++) bal[k] = bal[k] - 1;
    end
    holdReturns = hold;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NI; k++) bal[k] = 0;
    // R1: quiet output while reset is held
    curReq = "R1";
    repeat (4) step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) chk(g[k] == 2'd0, "R1", int'(g[k]), 0);
    rstN = 1'b1;

    // R2, R10, R6: start-up batch under hold, with one read folded in
    curReq = "R2";
    clearWin();
    for (int i = 0; i < 10; i++) step(i == 1, 1'b1);
    for (int k = 0; k < NI; k++) begin
      chk(winSum[k] == TG[k], "R2 R10 batch total", winSum[k], TG[k]);
      chk(winNz[k] == (TG[k] + 1) / 2, "R2 batch cycles", winNz[k], (TG[k] + 1) / 2);
    end
    curReq = "R6";
    clearWin();
    repeat (4) step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) chk(winSum[k] == 1, "R6 early read repaid", winSum[k], 1);

    // R4: single read repaid one cycle after the capturing edge
    curReq = "R4";
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) chk(g[k] == 2'd0, "R4 not same cycle", int'(g[k]), 0);
    step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) chk(g[k] == 2'd1, "R4 one credit", int'(g[k]), 1);

    // R7 then R5: withhold two returns, release as a pair
    curReq = "R7";
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    repeat (3) step(1'b0, 1'b1);
    for (int k = 0; k < NI; k++) chk(g[k] == 2'd0, "R7 withheld", int'(g[k]), 0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) chk(g[k] == 2'd2, "R5 pair release", int'(g[k]), 2);

    // Sweep every 8-cycle read pattern with returns open
    curReq = "R5";
    for (int pat = 0; pat < 256; pat++) begin
      for (int b = 0; b < 8; b++) step(pat[b], 1'b0);
    end

    // Sweep read patterns against interleaved hold patterns
    curReq = "R7";
    for (int pat = 0; pat < 256; pat++) begin
      int hp;
      hp = (pat * 29 + 7) & 255;
      for (int b = 0; b < 8; b++) step(pat[b], hp[b]);
    end

    // R8, R9: drain and confirm every target settles at its level
    curReq = "R8";
    repeat (10) step(1'b0, 1'b0);
    for (int k = 0; k < NI; k++) begin
      chk(bal[k] == TG[k], "R8 settled balance", bal[k], TG[k]);
      chk(bal[k] == TG[k] && g[k] == 2'd0, "R9 target honoured", bal[k], TG[k]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule